// File: doc/BRIEF.md
# Weak-Ordering Write Buffer with Counting Fence

This block sits between a processor's load/store port and a memory or network path whose latency varies. Loads and stores from the processor go into a small slot array. From there they issue to memory in whatever order a round-robin selector picks. They do not wait for earlier acknowledgements, so several transactions can be in flight at once. A counter tracks how many requests have issued but are not yet acknowledged. When that count reaches a parameter limit, issue pauses until an acknowledgement arrives.

Program order does not constrain what leaves the buffer. Reads may overtake buffered writes, and writes may leave in any order. Two protections keep single-address behaviour sane. A store to an address that already has a buffered store overwrites that slot's data, so the two merge into one write. Any load/store pair to the same address holds the processor off until the older access has left the array.

Ordering across addresses comes back only through the fence input. Once a fence is requested, the processor is refused. The block then waits until the slot array is empty and every issued request has been acknowledged, signals completion for one cycle, and reopens.

Top module: `wo_store_buffer`

## Requirements
- R1: After reset the block accepts accesses (`cpu_ready` high), requests nothing from memory (`mem_req_valid` low) and shows no fence completion.
- R2: A buffered access issues as soon as it is selected and the memory accepts it, without waiting for acknowledgements of earlier issued accesses.
- R3: While the count of issued but unacknowledged requests equals `MAX_OUT`, `mem_req_valid` stays low. One `mem_ack` pulse lets the next buffered access issue.
- R4: A store (`cpu_store`=1) to an address that already has a buffered, unissued store goes into that slot. Memory receives one write to that address carrying the newer data.
- R5: The next access to issue is the first occupied slot at or after a rotating pointer. After each issue the pointer moves to the slot just past the one that issued, wrapping at `NUM_SLOTS`. A free slot is taken lowest index first. Issue order therefore need not follow program order.
- R6: An incoming access whose address matches a buffered access holds `cpu_ready` low until the buffered one issues, unless both are stores. Loads to other addresses are accepted and may issue ahead of buffered stores.
- R7: From the cycle `fence_req` is high until `fence_done` pulses, `cpu_ready` is low. `fence_done` does not occur while any slot is occupied or any request is unacknowledged.
- R8: `fence_done` is high for exactly one cycle per fence. `cpu_ready` returns in the following cycle.
- R9: Each `mem_ack` cycle retires one issued request. The block stays ready to issue more after acknowledgements arrive in any number.
- R10: When every slot is occupied and the incoming access does not merge, `cpu_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor presents an access |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access taken this cycle when valid is high |
| fence_req | input | 1 | Request a fence |
| fence_done | output | 1 | One-cycle fence completion |
| mem_req_valid | output | 1 | Request to memory is presented |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_store | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_data | output | DATA_W | Write data |
| mem_ack | input | 1 | One request acknowledged this cycle |

## Verification
Several stimulus patterns each isolate one property.

- **Out-of-order issue:** a burst of stores sent with acknowledgements withheld shows that issue never waits on an acknowledgement. Running the same burst past the limit shows where issue stops, and that a single acknowledgement restarts it.
- **Rotating selection:** one store is issued first so the pointer sits mid-array. Three more stores are then queued behind a stalled memory. The order in which they leave tells rotating selection apart from fixed lowest-index priority and from program order.
- **Merging and blocking:** repeated stores to one address and a load that follows a store to the same address separate merging from blocking.
- **Full array:** filling every slot shows that a further access is refused.
- **Fences:** a fence over a busy buffer is compared with a fence over an empty one. This shows that completion waits for both the array and the counter, and that it lasts exactly one cycle.

// File: rtl/wob_pkg.sv
package wob_pkg;
  // advance a slot index by one, wrapping at n
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/wob_slots.sv
module wob_slots #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          look_store,
  input  logic [AW-1:0] look_addr,
  input  logic [DW-1:0] look_data,
  input  logic          acc_en,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  valid_q,
  output logic [N-1:0]  store_q,
  output logic [AW-1:0] addr_q [N],
  output logic [DW-1:0] data_q [N],
  output logic          hit,
  output logic          clash,
  output logic          free_any
);
  logic [N-1:0]  match;
  logic [IW-1:0] hit_idx, free_idx, tgt_idx;

  function automatic logic [IW-1:0] low_index(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) match[i] = valid_q[i] && (addr_q[i] == look_addr);
  end

  // at most one slot can match: merging and blocking keep addresses unique
  assign hit      = look_store && |(match & store_q);
  assign clash    = |(match & ~store_q) || (|match && !look_store);
  assign hit_idx  = low_index(match);
  assign free_any = |(~valid_q);
  assign free_idx = low_index(~valid_q);
  assign tgt_idx  = hit ? hit_idx : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (acc_en) valid_q[tgt_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      store_q[tgt_idx] <= look_store;
      addr_q[tgt_idx]  <= look_addr;
      data_q[tgt_idx]  <= look_data;
    end
  end

  // R6
  clash_block_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_en |-> !clash);
  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (acc_en && !hit) |-> free_any);
endmodule

// File: rtl/wob_rr.sv
module wob_rr #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_vec,
  input  logic          fire,
  output logic [IW-1:0] grant_idx
);
  logic [IW-1:0] ptr_q;

  function automatic logic [IW-1:0] pick(input logic [N-1:0] v, input logic [IW-1:0] p);
    logic [IW-1:0] r;
    logic          f;
    int            j;
    r = '0;
    f = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = (int'(p) + k) % N;
      if (!f && v[j]) begin
        r = IW'(j);
        f = 1'b1;
      end
    end
    return r;
  endfunction

  assign grant_idx = pick(req_vec, ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (fire) ptr_q <= IW'(wob_pkg::wrap_next(32'(grant_idx), N));
  end

  // R5
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |-> req_vec[grant_idx]);
endmodule

// File: rtl/wob_outstanding.sv
module wob_outstanding #(
  parameter int MAX_OUT = 8,
  parameter int CW      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic at_cap,
  output logic idle
);
  logic [CW-1:0] count_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic i, input logic d);
    case ({i, d})
      2'b10:   return c + CW'(1);
      2'b01:   return c - CW'(1);
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= step(count_q, inc, dec);
  end

  assign at_cap = (count_q == CW'(MAX_OUT));
  assign idle   = (count_q == '0);

  // R3
  cap_issue_chk: assert property (@(posedge clk) disable iff (!rst_n) at_cap |-> !inc);
  // R9
  ack_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) dec |-> !idle);
endmodule

// File: rtl/wo_store_buffer.sv
module wo_store_buffer #(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_OUT   = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_store,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic              fence_req,
  output logic              fence_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_store,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_ack
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CW = $clog2(MAX_OUT + 1);

  logic [NUM_SLOTS-1:0] valid_q, store_q;
  logic [ADDR_W-1:0]    addr_q [NUM_SLOTS];
  logic [DATA_W-1:0]    data_q [NUM_SLOTS];
  logic                 hit, clash, free_any;
  logic [IW-1:0]        grant_idx;
  logic                 at_cap, idle;
  logic                 acc_en, issue_fire, fence_hold, fence_active_q, drained;

  // a merge into the slot that issues this cycle keeps the slot: the new data goes out later
  wob_slots #(.N(NUM_SLOTS), .AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_slots (
    .clk, .rst_n,
    .look_store(cpu_store), .look_addr(cpu_addr), .look_data(cpu_wdata),
    .acc_en, .clr_en(issue_fire), .clr_idx(grant_idx),
    .valid_q, .store_q, .addr_q, .data_q,
    .hit, .clash, .free_any
  );

  wob_rr #(.N(NUM_SLOTS), .IW(IW)) u_rr (
    .clk, .rst_n, .req_vec(valid_q), .fire(issue_fire), .grant_idx
  );

  wob_outstanding #(.MAX_OUT(MAX_OUT), .CW(CW)) u_cnt (
    .clk, .rst_n, .inc(issue_fire), .dec(mem_ack), .at_cap, .idle
  );

  assign mem_req_valid = |valid_q && !at_cap;
  assign issue_fire    = mem_req_valid && mem_req_ready;
  assign mem_req_store = store_q[grant_idx];
  assign mem_req_addr  = addr_q[grant_idx];
  assign mem_req_data  = data_q[grant_idx];

  assign fence_hold = fence_req || fence_active_q;
  assign cpu_ready  = !fence_hold && !clash && (hit || free_any);
  assign acc_en     = cpu_valid && cpu_ready;

  assign drained    = !(|valid_q) && idle;
  assign fence_done = fence_active_q && drained;

  always_ff @(posedge clk) begin
    if (!rst_n)              fence_active_q <= 1'b0;
    else if (fence_active_q) fence_active_q <= !drained;
    else                     fence_active_q <= fence_req;
  end

  // R7
  fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) fence_active_q |-> !cpu_ready);
  // R7
  fence_drain_chk: assert property (@(posedge clk) disable iff (!rst_n) fence_done |-> (!mem_req_valid && !mem_ack));
  // R8
  fence_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) fence_done |=> !fence_done);
  // R8
  fence_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n) (fence_done && !fence_req) |=> !fence_active_q);
endmodule

// File: tb/tb_wo_store_buffer.sv
`timescale 1ns/100ps
module tb_wo_store_buffer;
  localparam int AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_store = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, fence_req = 1'b0, fence_done;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_store;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;
  logic mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int log_n = 0, done_cycles = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  logic          log_st   [64];

  always #2.5 clk = ~clk;

  wo_store_buffer dut (.*);

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready && log_n < 64) begin
      log_addr[log_n] = mem_req_addr;
      log_data[log_n] = mem_req_data;
      log_st[log_n]   = mem_req_store;
      log_n++;
    end
    if (rst_n && fence_done) done_cycles++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit expect_block, input string req);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_store = st; cpu_addr = a; cpu_wdata = d;
    #1;
    if (expect_block) chk(cpu_ready == 1'b0, req, cpu_ready, 0);
    forever begin
      @(posedge clk);
      if (cpu_ready) break;
    end
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic acks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mem_ack = 1'b1;
    end
    @(negedge clk); mem_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 req", mem_req_valid, 0);
    chk(fence_done == 1'b0, "R1 done", fence_done, 0);
  endtask

  task automatic t_no_wait;
    int base = log_n;
    push(1, 16'h0010, 32'h11, 0, "");
    push(1, 16'h0020, 32'h22, 0, "");
    push(1, 16'h0030, 32'h33, 0, "");
    idle(3);
    chk(log_n - base == 3, "R2 issued without acks", log_n - base, 3);
    acks(3);
    push(0, 16'h0040, 0, 0, "");
    idle(3);
    chk(log_n - base == 4 && log_st[base+3] == 1'b0, "R9 issue after acks", log_n - base, 4);
    acks(1);
  endtask

  task automatic t_cap;
    int base = log_n;
    for (int i = 0; i < 9; i++) push(1, 16'h0100 + 16'(i), 32'(i), 0, "");
    idle(3);
    chk(log_n - base == 8, "R3 issue count at cap", log_n - base, 8);
    chk(mem_req_valid == 1'b0, "R3 stalled at cap", mem_req_valid, 0);
    acks(1);
    idle(2);
    chk(log_n - base == 9 && log_addr[base+8] == 16'h0108, "R3 resume after ack",
        log_addr[base+8], 16'h0108);
    acks(8);
  endtask

  task automatic t_rr;
    int base;
    mem_req_ready = 1'b0;
    push(1, 16'h0A00, 32'hA, 0, "");
    base = log_n;
    @(negedge clk); mem_req_ready = 1'b1;
    @(negedge clk); mem_req_ready = 1'b0;
    push(1, 16'h0B00, 32'hB, 0, "");
    push(1, 16'h0C00, 32'hC, 0, "");
    push(1, 16'h0D00, 32'hD, 0, "");
    mem_req_ready = 1'b1;
    idle(5);
    chk(log_n - base == 4, "R5 count", log_n - base, 4);
    chk(log_addr[base+1] == 16'h0C00, "R5 first after pointer", log_addr[base+1], 16'h0C00);
    chk(log_addr[base+2] == 16'h0D00, "R5 second", log_addr[base+2], 16'h0D00);
    chk(log_addr[base+3] == 16'h0B00, "R5 wrap", log_addr[base+3], 16'h0B00);
    acks(4);
  endtask

  task automatic t_merge;
    int base = log_n, hits = 0;
    logic [DW-1:0] got = '0;
    mem_req_ready = 1'b0;
    push(1, 16'h0E00, 32'h1, 0, "");
    push(1, 16'h0E00, 32'h2, 0, "");
    push(1, 16'h0F00, 32'h3, 0, "");
    mem_req_ready = 1'b1;
    idle(4);
    for (int i = base; i < log_n; i++)
      if (log_addr[i] == 16'h0E00) begin hits++; got = log_data[i]; end
    chk(log_n - base == 2, "R4 merged count", log_n - base, 2);
    chk(hits == 1 && got == 32'h2, "R4 newer data", got, 32'h2);
    acks(2);
  endtask

  task automatic t_clash;
    int base = log_n;
    mem_req_ready = 1'b0;
    push(1, 16'h0500, 32'h5, 0, "");
    push(0, 16'h0600, 0, 0, "");
    chk(log_n == base, "R6 load to other address accepted", log_n - base, 0);
    fork
      push(0, 16'h0500, 0, 1, "R6 same-address load blocked");
      begin idle(3); mem_req_ready = 1'b1; end
    join
    idle(4);
    chk(log_n - base == 3 && log_st[base+2] == 1'b0 && log_addr[base+2] == 16'h0500,
        "R6 load after store", log_addr[base+2], 16'h0500);
    acks(3);
  endtask

  task automatic t_full;
    int base = log_n;
    mem_req_ready = 1'b0;
    for (int i = 0; i < 4; i++) push(1, 16'h0700 + 16'(i), 32'(i), 0, "");
    fork
      push(1, 16'h0800, 32'h8, 1, "R10 full array blocks");
      begin idle(3); mem_req_ready = 1'b1; end
    join
    idle(4);
    chk(log_n - base == 5, "R10 all issued", log_n - base, 5);
    acks(5);
  endtask

  task automatic t_fence;
    int d0;
    mem_req_ready = 1'b0;
    push(1, 16'h0900, 32'h9, 0, "");
    push(1, 16'h0910, 32'h9, 0, "");
    d0 = done_cycles;
    @(negedge clk); fence_req = 1'b1; #1;
    chk(cpu_ready == 1'b0, "R7 blocked at request", cpu_ready, 0);
    @(negedge clk); fence_req = 1'b0; mem_req_ready = 1'b1;
    idle(5);
    chk(done_cycles == d0, "R7 no done while unacked", done_cycles - d0, 0);
    chk(cpu_ready == 1'b0, "R7 blocked while pending", cpu_ready, 0);
    acks(2);
    idle(3);
    chk(done_cycles - d0 == 1, "R8 one-cycle pulse", done_cycles - d0, 1);
    chk(cpu_ready == 1'b1, "R8 reopened", cpu_ready, 1);
    d0 = done_cycles;
    @(negedge clk); fence_req = 1'b1;
    @(negedge clk); fence_req = 1'b0; #1;
    chk(fence_done == 1'b1, "R8 empty fence completes next cycle", fence_done, 1);
    idle(3);
    chk(done_cycles - d0 == 1, "R8 empty fence single pulse", done_cycles - d0, 1);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_wait();
    t_cap();
    t_rr();
    t_merge();
    t_clash();
    t_full();
    t_fence();
    idle(2);
    finish_run();
  end
endmodule